// File: doc/BRIEF.md
# DAT1 Interrupt Window Shaper

This block drives the in-band interrupt level and its output-enable for the DAT1 line of an SDIO-style card interface. All of its logic runs on sdclk. The upstream logic announces a nominal interrupt window two sdclk cycles ahead of time. It does this with a lookahead start pulse and a lookahead end pulse. The block keeps both pulses in short tap pipelines. It builds the driven level and the enable from the tap that each programmed advance selects.

The level and the enable each have their own start advance and their own end advance, each 0, 1 or 2 cycles early. One option bit delays both outputs by one extra cycle. The enable window is widened where needed so that it always covers the level window. The settings are captured only while no window is in flight. The outputs are gated at once by a global mask, by the DAT1-signalling enable and by a pending-interrupt flag.

There is no data stream in this block. Every pin is a plain control or status pin, so no valid/ready handshake applies.

Two rules apply to the inputs:
- A lookahead end pulse must come at least 3 cycles after its start pulse.
- The next start pulse must wait until both outputs have been idle for a cycle, which is 4 cycles after the end pulse.

Top module: `sdio_dat1_int_shaper`

## Requirements
- R1: While rst_n is low and after its release, with no lookahead pulses, dat1_int_out and dat1_int_oe are 0. The captured settings reset to all advances 0 and no delay.
- R2: Number the rising edge that samples win_start_la as edge 0. With all advances 0 and no delay, the level is first seen high after edge 2. Numbering the edge that samples win_end_la as edge u, the level is last seen high before edge u+2.
- R3: An advance code of 1 or 2 moves the affected transition that many sdclk cycles earlier. Code 3 behaves exactly like code 0.
- R4: The start and end advances of the level (lvl_start_adv, lvl_end_adv) and of the enable (oe_start_adv, oe_end_adv) act independently of one another.
- R5: With out_delay_en set, both outputs move one cycle later than they would with the bit clear.
- R6: The enable start advance used is the larger of the enable and level start advances. The enable end advance used is the smaller of the two end advances. So dat1_int_oe is high whenever dat1_int_out is high.
- R7: While int_mask is 1, both outputs are 0 in that same cycle. When int_mask returns to 0 inside a window, the window resumes.
- R8: While dat1_int_en is 0, both outputs are 0 in that same cycle.
- R9: While int_pending is 0, both outputs are 0 in that same cycle.
- R10: Setting inputs that change while a window is in flight have no effect on that window. They are captured at the first rising edge where the block is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | sdclk |
| rst_n | input | 1 | Active-low asynchronous reset |
| win_start_la | input | 1 | Lookahead pulse: the nominal window opens two cycles later |
| win_end_la | input | 1 | Lookahead pulse: the nominal window closes two cycles later |
| int_pending | input | 1 | An interrupt is pending |
| int_mask | input | 1 | Global interrupt mask, high suppresses |
| dat1_int_en | input | 1 | Enable for interrupt signalling on DAT1 |
| lvl_start_adv | input | 2 | Advance code for the level start |
| lvl_end_adv | input | 2 | Advance code for the level end |
| oe_start_adv | input | 2 | Advance code for the enable start |
| oe_end_adv | input | 2 | Advance code for the enable end |
| out_delay_en | input | 1 | Adds one cycle of output delay |
| dat1_int_out | output | 1 | Interrupt level on DAT1 |
| dat1_int_oe | output | 1 | Output-enable for DAT1 interrupt |

## Verification
A wrong tap selection, or wrong captured settings, shows up as an output edge that is one or two cycles off. The scoreboard catches this on the very cycle the edge was due. A broken coverage rule shows within one cycle as a level high while the enable is low. A gating fault shows in the same cycle that the mask, enable or pending input changes. A window that takes settings changed mid-flight shows as a moved end edge within three cycles of the change.

// File: rtl/sdint_pkg.sv
package sdint_pkg;
  localparam int ADV_W = 2;
  typedef logic [ADV_W-1:0] adv_t;

  typedef struct packed {
    adv_t lvl_st;
    adv_t lvl_end;
    adv_t oe_st;
    adv_t oe_end;
    logic dly;
  } shape_cfg_t;

  // Codes above the lookahead depth fall back to "no advance".
  function automatic adv_t adv_norm(adv_t code, int la);
    return (int'(code) > la) ? '0 : code;
  endfunction
endpackage

// File: rtl/sdint_tap_pipe.sv
module sdint_tap_pipe #(
  parameter int LA = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pulse_in,
  output logic [LA:0] taps
);
  logic [LA:0] stage;

  assign stage[0] = pulse_in;

  genvar g;
  generate
    for (g = 1; g <= LA; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage[g] <= 1'b0;
        else        stage[g] <= stage[g-1];
      end
    end
  endgenerate

  assign taps = stage;
endmodule

// File: rtl/sdint_tap_sel.sv
module sdint_tap_sel #(
  parameter int LA = 2
) (
  input  logic [LA:0]          taps,
  input  sdint_pkg::adv_t      adv,
  output logic                 hit
);
  // Advance a picks the tap that sees the pulse a cycles before nominal.
  always_comb begin
    hit = 1'b0;
    for (int i = 0; i <= LA; i++) begin
      if (i == LA - int'(adv)) hit = taps[i];
    end
  end
endmodule

// File: rtl/sdint_win_reg.sv
module sdint_win_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  input  logic dly_i,
  output logic win_q,
  output logic win_qd,
  output logic win_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= 1'b0;
      win_qd <= 1'b0;
    end else begin
      if (clr_i)      win_q <= 1'b0;
      else if (set_i) win_q <= 1'b1;
      win_qd <= win_q;
    end
  end

  assign win_o = dly_i ? win_qd : win_q;
endmodule

// File: rtl/sdio_dat1_int_shaper.sv
module sdio_dat1_int_shaper #(
  parameter int LOOKAHEAD = 2
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        win_start_la,
  input  logic                        win_end_la,
  input  logic                        int_pending,
  input  logic                        int_mask,
  input  logic                        dat1_int_en,
  input  logic [sdint_pkg::ADV_W-1:0] lvl_start_adv,
  input  logic [sdint_pkg::ADV_W-1:0] lvl_end_adv,
  input  logic [sdint_pkg::ADV_W-1:0] oe_start_adv,
  input  logic [sdint_pkg::ADV_W-1:0] oe_end_adv,
  input  logic                        out_delay_en,
  output logic                        dat1_int_out,
  output logic                        dat1_int_oe
);
  import sdint_pkg::*;

  localparam int LA = LOOKAHEAD;

  logic [LA:0] st_taps, end_taps;
  shape_cfg_t  cfg_next, cfg_q;
  adv_t        n_ls, n_le, n_os, n_oe;
  logic        lvl_set, lvl_clr, oe_set, oe_clr;
  logic        lvl_q, lvl_qd, lvl_w, oe_q, oe_qd, oe_w;
  logic        busy, gate, start_any;

  sdint_tap_pipe #(.LA(LA)) u_start_pipe (
    .clk(clk), .rst_n(rst_n), .pulse_in(win_start_la), .taps(st_taps));
  sdint_tap_pipe #(.LA(LA)) u_end_pipe (
    .clk(clk), .rst_n(rst_n), .pulse_in(win_end_la), .taps(end_taps));

  // Normalise codes and widen the enable window around the level window.
  always_comb begin
    n_ls = adv_norm(lvl_start_adv, LA);
    n_le = adv_norm(lvl_end_adv, LA);
    n_os = adv_norm(oe_start_adv, LA);
    n_oe = adv_norm(oe_end_adv, LA);
    cfg_next.lvl_st  = n_ls;
    cfg_next.lvl_end = n_le;
    cfg_next.oe_st   = (n_os > n_ls) ? n_os : n_ls;
    cfg_next.oe_end  = (n_oe < n_le) ? n_oe : n_le;
    cfg_next.dly     = out_delay_en;
  end

  assign busy = win_start_la | (|st_taps[LA:1]) | lvl_q | lvl_qd | oe_q | oe_qd;
  assign start_any = |st_taps;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    cfg_q <= '0;
    else if (!busy) cfg_q <= cfg_next;
  end

  sdint_tap_sel #(.LA(LA)) u_sel_lvl_st (.taps(st_taps),  .adv(cfg_q.lvl_st),  .hit(lvl_set));
  sdint_tap_sel #(.LA(LA)) u_sel_lvl_en (.taps(end_taps), .adv(cfg_q.lvl_end), .hit(lvl_clr));
  sdint_tap_sel #(.LA(LA)) u_sel_oe_st  (.taps(st_taps),  .adv(cfg_q.oe_st),   .hit(oe_set));
  sdint_tap_sel #(.LA(LA)) u_sel_oe_en  (.taps(end_taps), .adv(cfg_q.oe_end),  .hit(oe_clr));

  sdint_win_reg u_lvl_win (
    .clk(clk), .rst_n(rst_n), .set_i(lvl_set), .clr_i(lvl_clr), .dly_i(cfg_q.dly),
    .win_q(lvl_q), .win_qd(lvl_qd), .win_o(lvl_w));
  sdint_win_reg u_oe_win (
    .clk(clk), .rst_n(rst_n), .set_i(oe_set), .clr_i(oe_clr), .dly_i(cfg_q.dly),
    .win_q(oe_q), .win_qd(oe_qd), .win_o(oe_w));

  assign gate         = dat1_int_en & ~int_mask & int_pending;
  assign dat1_int_out = lvl_w & gate;
  assign dat1_int_oe  = oe_w & gate;

  // R6: the enable window encloses the level window
  assert_oe_covers_lvl_R6: assert property (@(posedge clk) disable iff (!rst_n)
    dat1_int_out |-> dat1_int_oe);

  // R10: captured settings hold while a window is in flight
  assert_cfg_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(cfg_q));

  // R2: the level only opens on the edge after a start pulse sits in the pipe
  assert_lvl_opens_on_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lvl_q) |-> $past(start_any));

  // R7: masked means silent
  assert_masked_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    int_mask |-> (!dat1_int_out && !dat1_int_oe));

  // R8: disabled means silent
  assert_disabled_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !dat1_int_en |-> (!dat1_int_out && !dat1_int_oe));
endmodule

// File: tb/sim_sdio_dat1_int_shaper.sv
module sim_sdio_dat1_int_shaper;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    logic l;
    logic o;
    int   r;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic win_start_la = 1'b0, win_end_la = 1'b0;
  logic int_pending = 1'b1, int_mask = 1'b0, dat1_int_en = 1'b1;
  logic [1:0] lvl_start_adv = 2'd0, lvl_end_adv = 2'd0, oe_start_adv = 2'd0, oe_end_adv = 2'd0;
  logic out_delay_en = 1'b0;
  logic dat1_int_out, dat1_int_oe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  exp_t sb[$];

  int cur_ls = 0, cur_le = 0, cur_os = 0, cur_oe = 0, cur_d = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sdio_dat1_int_shaper u0 (
    .clk(clk), .rst_n(rst_n), .win_start_la(win_start_la), .win_end_la(win_end_la),
    .int_pending(int_pending), .int_mask(int_mask), .dat1_int_en(dat1_int_en),
    .lvl_start_adv(lvl_start_adv), .lvl_end_adv(lvl_end_adv),
    .oe_start_adv(oe_start_adv), .oe_end_adv(oe_end_adv),
    .out_delay_en(out_delay_en), .dat1_int_out(dat1_int_out), .dat1_int_oe(dat1_int_oe));

  // Monitor: one expected item per cycle, sampled a quarter period after the edge.
  initial begin
    exp_t e;
    forever begin
      @(posedge clk);
      #(CLK_PERIOD/4);
      if (sb.size() > 0) begin
        e = sb.pop_front();
        checks++;
        if (dat1_int_out !== e.l || dat1_int_oe !== e.o) begin
          errors++;
          $display("FAIL R%0d: out/oe = %b/%b, expected %b/%b at %0t",
                   e.r, dat1_int_out, dat1_int_oe, e.l, e.o, $time);
        end
      end
    end
  end

  function automatic int nrm(int c);
    return (c == 3) ? 0 : c;
  endfunction

  task automatic step(input bit s, input bit en_p, input bit el, input bit eo, input int r);
    exp_t e;
    @(negedge clk);
    win_start_la = s;
    win_end_la   = en_p;
    e.l = el; e.o = eo; e.r = r;
    sb.push_back(e);
  endtask

  task automatic set_cfg(input int ls, input int le, input int os, input int oe, input int d);
    @(negedge clk);
    cur_ls = ls; cur_le = le; cur_os = os; cur_oe = oe; cur_d = d;
    lvl_start_adv = 2'(ls); lvl_end_adv = 2'(le);
    oe_start_adv = 2'(os); oe_end_adv = 2'(oe);
    out_delay_en = d[0];
    sb.push_back('{l: 1'b0, o: 1'b0, r: 10});
  endtask

  // One window of lookahead length L; mask is high for steps in [mlo, mhi).
  task automatic window(input int L, input int r, input bit chg, input int mlo, input int mhi);
    int ls, le, os, oe, d;
    bit g, el, eo;
    ls = nrm(cur_ls); le = nrm(cur_le);
    os = (nrm(cur_os) > ls) ? nrm(cur_os) : ls;
    oe = (nrm(cur_oe) < le) ? nrm(cur_oe) : le;
    d  = cur_d;
    for (int k = 0; k < L + 6; k++) begin
      @(negedge clk);
      if (chg && k == 1) begin
        lvl_start_adv = 2'd2; lvl_end_adv = 2'd2;
        oe_start_adv = 2'd2; oe_end_adv = 2'd2; out_delay_en = 1'b1;
      end
      int_mask = (k >= mlo && k < mhi);
      win_start_la = (k == 0);
      win_end_la   = (k == L);
      g  = dat1_int_en & ~int_mask & int_pending;
      el = g && (k >= 2 - ls + d) && (k < L + 2 - le + d);
      eo = g && (k >= 2 - os + d) && (k < L + 2 - oe + d);
      sb.push_back('{l: el, o: eo, r: r});
    end
    int_mask = 1'b0;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: outputs quiet in and after reset
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
    @(negedge clk);
    rst_n = 1'b1;
    sb.push_back('{l: 1'b0, o: 1'b0, r: 1});
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
    // R1/R2: reset settings give nominal timing
    window(4, 2, 0, -1, -1);
    // R2: longer nominal window
    set_cfg(0, 0, 0, 0, 0);
    window(7, 2, 0, -1, -1);
    // R3: advance codes 2 and 1
    set_cfg(2, 1, 2, 1, 0);
    window(4, 3, 0, -1, -1);
    // R3: code 3 equals code 0
    set_cfg(3, 3, 3, 3, 0);
    window(4, 3, 0, -1, -1);
    // R4: enable shaped independently of level
    set_cfg(0, 2, 2, 0, 0);
    window(4, 4, 0, -1, -1);
    set_cfg(1, 0, 2, 0, 0);
    window(5, 4, 0, -1, -1);
    // R6: enable pulled out to cover level
    set_cfg(2, 0, 0, 2, 0);
    window(4, 6, 0, -1, -1);
    set_cfg(1, 1, 0, 2, 0);
    window(3, 6, 0, -1, -1);
    // R5: one-cycle output delay
    set_cfg(0, 0, 0, 0, 1);
    window(4, 5, 0, -1, -1);
    set_cfg(2, 1, 2, 0, 1);
    window(4, 5, 0, -1, -1);
    // R7: mask inside the window, then released
    set_cfg(2, 0, 2, 0, 0);
    window(6, 7, 0, 2, 4);
    // R8: signalling disabled
    @(negedge clk); dat1_int_en = 1'b0;
    sb.push_back('{l: 1'b0, o: 1'b0, r: 8});
    window(4, 8, 0, -1, -1);
    @(negedge clk); dat1_int_en = 1'b1;
    sb.push_back('{l: 1'b0, o: 1'b0, r: 8});
    // R9: nothing pending
    @(negedge clk); int_pending = 1'b0;
    sb.push_back('{l: 1'b0, o: 1'b0, r: 9});
    window(4, 9, 0, -1, -1);
    @(negedge clk); int_pending = 1'b1;
    sb.push_back('{l: 1'b0, o: 1'b0, r: 9});
    // R10: settings changed mid-window are ignored for that window
    set_cfg(0, 0, 0, 0, 0);
    window(5, 10, 1, -1, -1);
    // R10: new settings take effect on the following window
    cur_ls = 2; cur_le = 2; cur_os = 2; cur_oe = 2; cur_d = 1;
    window(4, 10, 0, -1, -1);
    for (int i = 0; i < 3; i++) step(0, 0, 0, 0, 1);
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule